// File: doc/BRIEF.md
# UART register file

This block is the byte-wide register front end of a 16450/16550-class UART. A host bus uses it to read and write eight register offsets through an address, a read strobe, a write strobe and write data. Read data is combinational and valid in the cycle that `bus_rd` is high. Read and write side effects take place at the clock edge that ends that cycle. The block holds the transmit and receive FIFOs. It pushes characters into them and pops characters out of them. It keeps the line status bits current and hands the configuration registers to the serializer and to the interrupt logic next to it.

While bit 7 of the line control register is set, offsets 0 and 1 reach the two divisor bytes in place of the data register and the interrupt enable register. The FIFO control write sets the queue depth: 16 entries in FIFO mode, 1 entry in single-character mode. When the enable bit changes, that write flushes both queues.

Transmit characters leave on a valid/ready stream. A character moves on any cycle where `tx_valid` and `tx_ready` are both high, and `tx_data` holds steady while `tx_ready` is low. The receive side has no back-pressure. A character offered with `rx_valid` is always taken. When the receive queue is full, the character is discarded and the loss is recorded in the line status.

Top module: `uart_regfile`

## Requirements
- R1: After reset the line status reads 0x60, `thre_pend` is 1, the divisor, IER and LCR are 0, both queues are empty, and `fifo_mode` equals the `FIFO_AT_RESET` parameter.
- R2: While LCR bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte, and nothing is pushed to the transmit queue. While LCR bit 7 is 0, offset 1 is IER, whose upper four bits read as 0.
- R3: A write to offset 0 with LCR bit 7 clear appends the byte to the transmit queue. If the queue is full, the byte replaces the entry at the write position and the occupancy does not change. Characters leave on the stream in write order.
- R4: A transmit write clears LSR bit 5 (holding empty), LSR bit 6 (transmitter empty) and `thre_pend`.
- R5: A write to offset 2 sets 16-entry mode when bit 0 is 1 and 1-entry mode when bit 0 is 0. If bit 0 differs from the current mode, both queues are flushed.
- R6: Setting bit 2 of the offset 2 write flushes the transmit queue and clears LSR bit 5 and `thre_pend`. Setting bit 1 flushes the receive queue and clears LSR bit 0 (data ready).
- R7: A read of offset 0 with LCR bit 7 clear returns the oldest received byte and pops it. After the read, LSR bit 0 shows whether entries remain, and `rx_idle_cnt` restarts from 0.
- R8: A read of offset 2 returns `{2'b11, 2'b00, iir_code}`. When IER bit 1 is set, the read also clears `thre_pend`; otherwise `thre_pend` is unchanged.
- R9: A read of offset 5 returns the line status and then clears bits 1 (overrun), 2 (parity), 3 (framing), 4 (break) and 7 (receive error). A character that arrives with its error flags sets the matching bit, and sets bit 7 as well.
- R10: A read of offset 6 returns the modem status and then clears it. `msr_set` bits are OR-ed into the modem status on every cycle.
- R11: Offset 4 always reads 0, while `cfg_mcr` holds the five low bits last written. Offset 7 reads back the last byte written to it.
- R12: A character offered while the receive queue is full is discarded and sets LSR bits 1 and 7. Any offered character sets LSR bit 0 and restarts `rx_idle_cnt`, which otherwise counts cycles while LSR bit 0 is set.
- R13: Addresses 8 and above are unmapped. Writes to them change nothing, and reads return 0.
- R14: The pop that empties the transmit queue sets LSR bit 5 and `thre_pend`. LSR bit 6 sets once the queue is empty and `tx_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| tx_valid | output | 1 | Transmit queue holds a character |
| tx_ready | input | 1 | Serializer takes the character |
| tx_data | output | 8 | Oldest transmit character |
| tx_busy | input | 1 | Serializer is still shifting |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error on this character |
| rx_ferr | input | 1 | Framing error on this character |
| rx_brk | input | 1 | Break seen with this character |
| iir_code | input | 4 | Interrupt identification from the prioritiser |
| msr_set | input | 8 | Modem status bits to set |
| cfg_div | output | 16 | Baud divisor |
| cfg_lcr | output | 8 | Line control |
| cfg_ier | output | 4 | Interrupt enables |
| cfg_mcr | output | 5 | Modem control |
| fifo_mode | output | 1 | 1 selects 16-entry queues |
| rx_trig | output | 2 | Receive trigger level field |
| rx_count | output | CW | Receive queue occupancy |
| thre_pend | output | 1 | Holding-empty interrupt pending |
| rx_idle_cnt | output | TO_W | Cycles since the last receive activity while data is ready |

## Verification
A wrong queue pointer or count shows up at once as a wrong byte or wrong occupancy on the next data read or stream transfer, and random receive traffic is checked against a reference queue. A status bit that was left set or cleared by mistake shows in the next line status read, or on `thre_pend` one cycle after the access that should have changed it. The read-to-clear bits are read twice, so a clear that did not happen shows on the second read. A mode toggle that fails to flush shows up as nonzero occupancy in the cycle after the control write.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  typedef enum logic [2:0] {
    OFF_DATA = 3'd0,
    OFF_IER  = 3'd1,
    OFF_IIR  = 3'd2,
    OFF_LCR  = 3'd3,
    OFF_MCR  = 3'd4,
    OFF_LSR  = 3'd5,
    OFF_MSR  = 3'd6,
    OFF_SCR  = 3'd7
  } reg_off_e;

  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_PE   = 2;
  localparam int LSR_FE   = 3;
  localparam int LSR_BI   = 4;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam int LSR_RXFE = 7;

  localparam logic [7:0] LSR_RD_CLR = 8'h9E;
  localparam logic [7:0] LSR_RESET  = 8'h60;

  typedef struct packed {
    logic thr_wr;
    logic rbr_rd;
    logic dll_wr;
    logic dll_rd;
    logic dlm_wr;
    logic dlm_rd;
    logic ier_wr;
    logic ier_rd;
    logic iir_rd;
    logic fcr_wr;
    logic lcr_wr;
    logic lcr_rd;
    logic mcr_wr;
    logic mcr_rd;
    logic lsr_rd;
    logic msr_rd;
    logic scr_wr;
    logic scr_rd;
  } acc_t;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              dlab,
  output acc_t              acc
);

  logic       hit;
  logic [2:0] off;

  generate
    if (ADDR_W > 3) begin : g_wide
      assign hit = (addr[ADDR_W-1:3] == '0);
    end else begin : g_narrow
      assign hit = 1'b1;
    end
  endgenerate

  assign off = addr[2:0];

  always_comb begin
    acc = '0;
    if (hit) begin
      unique case (reg_off_e'(off))
        OFF_DATA: begin
          if (dlab) begin
            acc.dll_wr = wr;
            acc.dll_rd = rd;
          end else begin
            acc.thr_wr = wr;
            acc.rbr_rd = rd;
          end
        end
        OFF_IER: begin
          if (dlab) begin
            acc.dlm_wr = wr;
            acc.dlm_rd = rd;
          end else begin
            acc.ier_wr = wr;
            acc.ier_rd = rd;
          end
        end
        OFF_IIR: begin
          acc.iir_rd = rd;
          acc.fcr_wr = wr;
        end
        OFF_LCR: begin
          acc.lcr_wr = wr;
          acc.lcr_rd = rd;
        end
        OFF_MCR: begin
          acc.mcr_wr = wr;
          acc.mcr_rd = rd;
        end
        OFF_LSR: acc.lsr_rd = rd;
        OFF_MSR: acc.msr_rd = rd;
        OFF_SCR: begin
          acc.scr_wr = wr;
          acc.scr_rd = rd;
        end
        default: acc = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter bit OVERWRITE = 1'b0,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          deep,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] lim;
  logic          full, do_pop, take, wr_en;

  assign lim    = deep ? CW'(DEPTH) : CW'(1);
  assign full   = (count == lim);
  assign do_pop = pop && (count != '0);
  assign take   = push && (!full || do_pop);

  generate
    if (OVERWRITE) begin : g_ovw
      assign wr_en = push;
    end else begin : g_drop
      assign wr_en = take;
    end
  endgenerate

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic d);
    return (d && p != PW'(DEPTH - 1)) ? p + 1'b1 : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (take)   wp <= step(wp, deep);
      if (do_pop) rp <= step(rp, deep);
      count <= count + CW'(take) - CW'(do_pop);
    end
  end

  assign rdata = mem[rp];

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= lim);

  p_full_push_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !do_pop && !clr) |=> (count == $past(count)));

endmodule

// File: rtl/uart_rf_status.sv
module uart_rf_status
  import uart_rf_pkg::*;
#(
  parameter int CW   = 5,
  parameter int TO_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            thr_wr,
  input  logic            rbr_rd,
  input  logic            iir_rd,
  input  logic            lsr_rd,
  input  logic            msr_rd,
  input  logic            ier_thre,
  input  logic            tx_clr,
  input  logic            rx_clr,
  input  logic            tx_pop,
  input  logic [CW-1:0]   tx_count,
  input  logic            tx_busy,
  input  logic            rx_valid,
  input  logic            rx_full,
  input  logic [CW-1:0]   rx_count,
  input  logic            rx_perr,
  input  logic            rx_ferr,
  input  logic            rx_brk,
  input  logic [7:0]      msr_set,
  output logic [7:0]      lsr,
  output logic [7:0]      msr,
  output logic            thre_pend,
  output logic [TO_W-1:0] idle_cnt
);

  logic [7:0] lsr_n;
  logic       pend_n;
  logic       drop;

  assign drop = rx_valid && rx_full && !rbr_rd;

  always_comb begin
    lsr_n  = lsr;
    pend_n = thre_pend;
    if (lsr_rd) lsr_n = lsr_n & ~LSR_RD_CLR;
    // transmit side: set on drain, clears take precedence
    if (tx_pop && tx_count == CW'(1)) begin
      lsr_n[LSR_THRE] = 1'b1;
      pend_n          = 1'b1;
    end
    if (tx_count == '0 && !tx_busy) lsr_n[LSR_TEMT] = 1'b1;
    if (thr_wr) begin
      lsr_n[LSR_THRE] = 1'b0;
      lsr_n[LSR_TEMT] = 1'b0;
      pend_n          = 1'b0;
    end
    if (tx_clr) begin
      lsr_n[LSR_THRE] = 1'b0;
      pend_n          = 1'b0;
    end
    if (iir_rd && ier_thre) pend_n = 1'b0;
    // receive side
    if (rbr_rd) lsr_n[LSR_DR] = (rx_count > CW'(1));
    if (rx_valid) begin
      lsr_n[LSR_DR] = 1'b1;
      if (rx_perr) lsr_n[LSR_PE] = 1'b1;
      if (rx_ferr) lsr_n[LSR_FE] = 1'b1;
      if (rx_brk)  lsr_n[LSR_BI] = 1'b1;
      if (rx_perr || rx_ferr || rx_brk) lsr_n[LSR_RXFE] = 1'b1;
    end
    if (drop) begin
      lsr_n[LSR_OE]   = 1'b1;
      lsr_n[LSR_RXFE] = 1'b1;
    end
    if (rx_clr) lsr_n[LSR_DR] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsr       <= LSR_RESET;
      thre_pend <= 1'b1;
      msr       <= '0;
      idle_cnt  <= '0;
    end else begin
      lsr       <= lsr_n;
      thre_pend <= pend_n;
      msr       <= msr_rd ? msr_set : (msr | msr_set);
      if (rbr_rd || rx_valid)                   idle_cnt <= '0;
      else if (lsr[LSR_DR] && idle_cnt != '1)   idle_cnt <= idle_cnt + 1'b1;
    end
  end

  p_thr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (!thre_pend && !lsr[LSR_THRE] && !lsr[LSR_TEMT]));

  p_iir_clears_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && ier_thre) |=> !thre_pend);

  p_lsr_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid) |=> ((lsr & LSR_RD_CLR) == 8'h00));

  p_msr_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && msr_set == 8'h00) |=> (msr == 8'h00));

  p_idle_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd |=> (idle_cnt == '0));

  p_rx_sets_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_clr) |=> lsr[LSR_DR]);

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int FIFO_DEPTH    = 16,
  parameter bit FIFO_AT_RESET = 1'b1,
  parameter int TO_W          = 10,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              tx_busy,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic [3:0]        iir_code,
  input  logic [7:0]        msr_set,
  output logic [15:0]       cfg_div,
  output logic [7:0]        cfg_lcr,
  output logic [3:0]        cfg_ier,
  output logic [4:0]        cfg_mcr,
  output logic              fifo_mode,
  output logic [1:0]        rx_trig,
  output logic [CW-1:0]     rx_count,
  output logic              thre_pend,
  output logic [TO_W-1:0]   rx_idle_cnt
);

  acc_t          acc;
  logic [7:0]    dll, dlm, scr, lsr, msr, rx_head;
  logic          toggle, tx_clr, rx_clr, tx_pop, rx_full;
  logic [CW-1:0] tx_count;

  uart_rf_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .dlab (cfg_lcr[7]),
    .acc  (acc)
  );

  // FIFO control: a change of the enable bit flushes both queues
  assign toggle = acc.fcr_wr && (bus_wdata[0] != fifo_mode);
  assign tx_clr = acc.fcr_wr && (bus_wdata[2] || toggle);
  assign rx_clr = acc.fcr_wr && (bus_wdata[1] || toggle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll       <= '0;
      dlm       <= '0;
      cfg_lcr   <= '0;
      cfg_ier   <= '0;
      cfg_mcr   <= '0;
      scr       <= '0;
      fifo_mode <= FIFO_AT_RESET;
      rx_trig   <= '0;
    end else begin
      if (acc.dll_wr) dll     <= bus_wdata;
      if (acc.dlm_wr) dlm     <= bus_wdata;
      if (acc.lcr_wr) cfg_lcr <= bus_wdata;
      if (acc.ier_wr) cfg_ier <= bus_wdata[3:0];
      if (acc.mcr_wr) cfg_mcr <= bus_wdata[4:0];
      if (acc.scr_wr) scr     <= bus_wdata;
      if (acc.fcr_wr) begin
        fifo_mode <= bus_wdata[0];
        rx_trig   <= bus_wdata[7:6];
      end
    end
  end

  assign cfg_div = {dlm, dll};

  assign tx_valid = (tx_count != '0);
  assign tx_pop   = tx_valid && tx_ready;

  uart_rf_fifo #(.DW(8), .DEPTH(FIFO_DEPTH), .OVERWRITE(1'b1)) i_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tx_clr),
    .deep  (fifo_mode),
    .push  (acc.thr_wr),
    .wdata (bus_wdata),
    .pop   (tx_pop),
    .rdata (tx_data),
    .count (tx_count)
  );

  uart_rf_fifo #(.DW(8), .DEPTH(FIFO_DEPTH), .OVERWRITE(1'b0)) i_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .deep  (fifo_mode),
    .push  (rx_valid),
    .wdata (rx_data),
    .pop   (acc.rbr_rd),
    .rdata (rx_head),
    .count (rx_count)
  );

  assign rx_full = (rx_count == (fifo_mode ? CW'(FIFO_DEPTH) : CW'(1)));

  uart_rf_status #(.CW(CW), .TO_W(TO_W)) i_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_wr    (acc.thr_wr),
    .rbr_rd    (acc.rbr_rd),
    .iir_rd    (acc.iir_rd),
    .lsr_rd    (acc.lsr_rd),
    .msr_rd    (acc.msr_rd),
    .ier_thre  (cfg_ier[1]),
    .tx_clr    (tx_clr),
    .rx_clr    (rx_clr),
    .tx_pop    (tx_pop),
    .tx_count  (tx_count),
    .tx_busy   (tx_busy),
    .rx_valid  (rx_valid),
    .rx_full   (rx_full),
    .rx_count  (rx_count),
    .rx_perr   (rx_perr),
    .rx_ferr   (rx_ferr),
    .rx_brk    (rx_brk),
    .msr_set   (msr_set),
    .lsr       (lsr),
    .msr       (msr),
    .thre_pend (thre_pend),
    .idle_cnt  (rx_idle_cnt)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (acc.rbr_rd)      bus_rdata = rx_head;
    else if (acc.dll_rd) bus_rdata = dll;
    else if (acc.dlm_rd) bus_rdata = dlm;
    else if (acc.ier_rd) bus_rdata = {4'b0000, cfg_ier};
    else if (acc.iir_rd) bus_rdata = {2'b11, 2'b00, iir_code};
    else if (acc.lcr_rd) bus_rdata = cfg_lcr;
    else if (acc.mcr_rd) bus_rdata = 8'h00;
    else if (acc.lsr_rd) bus_rdata = lsr;
    else if (acc.msr_rd) bus_rdata = msr;
    else if (acc.scr_rd) bus_rdata = scr;
  end

  p_fcr_toggle_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> (rx_count == '0 && !tx_valid));

  p_dlab_no_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && cfg_lcr[7] && !tx_valid) |=> !tx_valid);

endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       tx_valid, tx_ready = 1'b0, tx_busy = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_data = '0;
  logic [3:0] iir_code = 4'h1;
  logic [7:0] msr_set = '0;
  logic [15:0] cfg_div;
  logic [7:0]  cfg_lcr;
  logic [3:0]  cfg_ier;
  logic [4:0]  cfg_mcr;
  logic        fifo_mode, thre_pend;
  logic [1:0]  rx_trig;
  logic [4:0]  rx_count;
  logic [9:0]  rx_idle_cnt;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  uart_regfile i_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .iir_code(iir_code),
    .msr_set(msr_set), .cfg_div(cfg_div), .cfg_lcr(cfg_lcr), .cfg_ier(cfg_ier),
    .cfg_mcr(cfg_mcr), .fifo_mode(fifo_mode), .rx_trig(rx_trig), .rx_count(rx_count),
    .thre_pend(thre_pend), .rx_idle_cnt(rx_idle_cnt)
  );

  function automatic logic [7:0] lsr_exp(input bit dr, input bit oe, input bit pe, input bit fe,
                                         input bit bi, input bit thre, input bit temt, input bit rxfe);
    return {rxfe, temt, thre, bi, fe, pe, oe, dr};
  endfunction

  function automatic logic [7:0] iir_exp(input logic [3:0] code);
    return {2'b11, 2'b00, code};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d, input bit pe, input bit fe, input bit bi);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bi;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] q[$];
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(thre_pend == 1'b1 && fifo_mode == 1'b1 && cfg_div == 16'h0 && rx_count == 0
          && !tx_valid && cfg_lcr == 8'h0 && cfg_ier == 4'h0, "R1 reset outputs",
          {thre_pend, fifo_mode, rx_count}, 7'b1100000);
    bus_read(4'd5, rd);
    check(rd == lsr_exp(0,0,0,0,0,1,1,0), "R1 reset LSR", rd, 8'h60);
    bus_read(4'd2, rd);
    check(rd == iir_exp(4'h1), "R8 IIR value", rd, iir_exp(4'h1));
    check(thre_pend == 1'b1, "R8 IIR read with THRE disabled keeps pending", thre_pend, 1);

    // R11 scratch and modem control
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      bus_write(4'd7, v);
      bus_read(4'd7, rd);
      check(rd == v, "R11 scratch readback", rd, v);
    end
    bus_write(4'd4, 8'hFF);
    bus_read(4'd4, rd);
    check(rd == 8'h00 && cfg_mcr == 5'h1F, "R11 MCR reads zero", {rd, 3'b000, cfg_mcr}, 16'h001F);

    // R13 unmapped offsets
    bus_write(4'd7, 8'h5A);
    bus_write(4'd9, 8'hFF);
    bus_write(4'd15, 8'hFF);
    bus_read(4'd9, rd);
    check(rd == 8'h00, "R13 unmapped read", rd, 0);
    bus_read(4'd7, rd);
    check(rd == 8'h5A && cfg_lcr == 8'h00 && cfg_ier == 4'h0, "R13 unmapped write ignored", rd, 8'h5A);

    // R2 divisor banking
    bus_write(4'd3, 8'h80);
    bus_write(4'd0, 8'h34);
    bus_write(4'd1, 8'h12);
    check(cfg_div == 16'h1234 && !tx_valid && cfg_ier == 4'h0, "R2 divisor write", cfg_div, 16'h1234);
    bus_read(4'd0, rd);
    check(rd == 8'h34, "R2 divisor low read", rd, 8'h34);
    bus_write(4'd3, 8'h03);
    bus_write(4'd1, 8'hFF);
    bus_read(4'd1, rd);
    check(rd == 8'h0F && cfg_div == 16'h1234, "R2 IER when bank closed", rd, 8'h0F);
    bus_write(4'd1, 8'h00);

    // R3/R4/R14 transmit in 16-entry mode
    bus_write(4'd0, 8'hA1);
    bus_write(4'd0, 8'hB2);
    bus_write(4'd0, 8'hC3);
    check(thre_pend == 1'b0, "R4 THR write clears pending", thre_pend, 0);
    bus_read(4'd5, rd);
    check(rd == lsr_exp(0,0,0,0,0,0,0,0), "R4 THR write clears LSR 5/6", rd, 0);
    @(negedge clk);
    tx_ready = 1'b1;
    check(tx_valid && tx_data == 8'hA1, "R3 order first", tx_data, 8'hA1);
    @(negedge clk);
    check(tx_valid && tx_data == 8'hB2, "R3 order second", tx_data, 8'hB2);
    @(negedge clk);
    check(tx_valid && tx_data == 8'hC3, "R3 order third", tx_data, 8'hC3);
    @(negedge clk);
    tx_ready = 1'b0;
    check(!tx_valid && thre_pend, "R14 drain sets pending", thre_pend, 1);
    @(negedge clk);
    bus_read(4'd5, rd);
    check(rd == lsr_exp(0,0,0,0,0,1,1,0), "R14 drain LSR", rd, 8'h60);

    // R5/R6 switch to 1-entry mode (toggle flushes)
    bus_write(4'd2, 8'h00);
    check(fifo_mode == 1'b0 && thre_pend == 1'b0, "R6 TX flush clears pending", thre_pend, 0);
    bus_read(4'd5, rd);
    check(rd == lsr_exp(0,0,0,0,0,0,1,0), "R6 TX flush clears LSR 5", rd, 8'h40);
    bus_write(4'd0, 8'h11);
    bus_write(4'd0, 8'h22);
    check(tx_valid && tx_data == 8'h22, "R3 full overwrite", tx_data, 8'h22);
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    check(!tx_valid && thre_pend, "R3 single entry after overwrite", tx_valid, 0);
    @(negedge clk);

    // R12/R7/R9 receive overflow in 1-entry mode
    rx_push(8'h55, 0, 0, 0);
    rx_push(8'h66, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(rx_idle_cnt != 0 && rx_count == 1, "R12 idle counts while ready", rx_idle_cnt, 1);
    bus_read(4'd5, rd);
    check(rd == lsr_exp(1,1,0,0,0,1,1,1), "R12 overflow flags", rd, 8'hE3);
    bus_read(4'd5, rd);
    check(rd == lsr_exp(1,0,0,0,0,1,1,0), "R9 read clears errors", rd, 8'h61);
    bus_read(4'd0, rd);
    check(rd == 8'h55, "R12 dropped char not stored", rd, 8'h55);
    check(rx_idle_cnt == 0 && rx_count == 0, "R7 pop restarts idle count", rx_idle_cnt, 0);
    bus_read(4'd5, rd);
    check(rd[0] == 1'b0, "R7 data ready clears when empty", rd, 8'h60);

    // R5/R6 back to 16-entry mode, then receive flush without toggle
    bus_write(4'd2, 8'hC1);
    check(fifo_mode == 1'b1 && rx_trig == 2'b11, "R5 enable FIFO mode", fifo_mode, 1);
    rx_push(8'h01, 0, 0, 0);
    rx_push(8'h02, 0, 0, 0);
    check(rx_count == 2, "R5 16-entry mode holds two", rx_count, 2);
    bus_write(4'd2, 8'h03);
    check(rx_count == 0 && fifo_mode == 1'b1, "R6 RX flush", rx_count, 0);
    bus_read(4'd5, rd);
    check(rd[0] == 1'b0, "R6 RX flush clears data ready", rd[0], 0);

    // R8 IIR clears pending only when enabled
    bus_write(4'd0, 8'h77);
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    iir_code = 4'h2;
    bus_read(4'd2, rd);
    check(rd == iir_exp(4'h2) && thre_pend, "R8 IIR disabled keeps pending", rd, iir_exp(4'h2));
    bus_write(4'd1, 8'h02);
    bus_read(4'd2, rd);
    check(thre_pend == 1'b0, "R8 IIR enabled clears pending", thre_pend, 0);
    bus_write(4'd1, 8'h00);

    // R10 modem status
    @(negedge clk);
    msr_set = 8'h0B;
    @(negedge clk);
    msr_set = 8'h00;
    bus_read(4'd6, rd);
    check(rd == 8'h0B, "R10 MSR captures", rd, 8'h0B);
    bus_read(4'd6, rd);
    check(rd == 8'h00, "R10 MSR read clears", rd, 0);

    // R9 receive error flags
    rx_push(8'hEE, 1, 1, 1);
    bus_read(4'd5, rd);
    check(rd == lsr_exp(1,0,1,1,1,1,1,1), "R9 error flags", rd, 8'hFD);
    bus_read(4'd5, rd);
    check(rd == lsr_exp(1,0,0,0,0,1,1,0), "R9 second read", rd, 8'h61);
    bus_read(4'd0, rd);
    check(rd == 8'hEE, "R7 error char data", rd, 8'hEE);

    // R7/R12 random receive traffic against a reference queue
    for (int i = 0; i < 80; i++) begin
      if (($urandom % 3) != 0) begin
        logic [7:0] v;
        v = 8'($urandom);
        rx_push(v, 0, 0, 0);
        if (q.size() < 16) q.push_back(v);
      end else begin
        bus_read(4'd0, rd);
        if (q.size() != 0) begin
          logic [7:0] e;
          e = q.pop_front();
          check(rd == e, "R7 random pop data", rd, e);
        end
      end
      check(rx_count == 5'(q.size()), "R12 random occupancy", rx_count, q.size());
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule